// File: doc/BRIEF.md
# Hint-Filtered Pointer-Scan Prefetch Generator

This block sits beside the fill path of a cache. Every cache line that arrives is presented once, with its address and data. The line also carries the recursion depth of the request that fetched it, the byte offset within the line that the triggering load touched, and a 16-bit hint vector that compile-time profiling attached to that load. The block treats each aligned 32-bit word of the line as a possible virtual address. A word is a pointer candidate when its most significant bits equal those of the line's own address.

Most such candidates are thrown away. A candidate survives only when three things hold: its distance from the touched byte is selected by the hint vector, it is neither zero nor the line's own base address, and the request it would create stays within a programmable depth limit. Each surviving word becomes a prefetch request for the address it holds, tagged with the parent depth plus one. Requests leave one per cycle, lowest word first, over a valid/ready handshake. While requests from a line are still outstanding, the block refuses the next line.

Top module: `ptr_prefetch_gen`

## Requirements
- R1: A word is a candidate only when its bits [31:24] equal bits [31:24] of `fill_addr`. Words that differ there are never issued.
- R2: Word i of the line sits at `fill_data[32*i +: 32]`, i = 0..15, and is its own candidate. An issued request carries exactly that word's value on `pf_addr`.
- R3: For word i, let rel = 4*i - `fill_off`. The word is issued only when rel >= 0 and hint bit (rel >> 2) is 1. Words with 4*i < `fill_off`, or whose hint bit is 0, are dropped. Examples: offset 8 selects bit 2, offset 24 bit 6, offset 44 bit 11.
- R4: Every request from a line carries `pf_depth` = `fill_depth` + 1. A demand-fetched line is presented with depth 0.
- R5: When `fill_depth` + 1 > `max_depth` (compared without wrap-around), the line produces no request at all. `max_depth` is read when the line is accepted.
- R6: A word equal to zero, or equal to the line base (`fill_addr` with bits [5:0] cleared), is never issued.
- R7: Requests leave one per handshake in ascending word order. While `pf_valid` is high and `pf_ready` is low, `pf_addr` and `pf_depth` hold.
- R8: Out of reset, `fill_ready` = 1 and `pf_valid` = 0. `fill_ready` stays 0 from the cycle after a line with surviving candidates is accepted until its last request has been taken. A line with no surviving candidates leaves `fill_ready` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_valid | input | 1 | A filled line is presented |
| fill_ready | output | 1 | Block can take a new line |
| fill_addr | input | 32 | Address of the filled line |
| fill_data | input | 512 | Line data, word i at bits [32*i +: 32] |
| fill_depth | input | 3 | Depth of the request that fetched the line |
| fill_off | input | 6 | Byte in the line touched by the triggering load |
| fill_hint | input | 16 | Hint vector of the triggering load |
| max_depth | input | 3 | Largest depth a request may carry |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_ready | input | 1 | Consumer takes the request |
| pf_addr | output | 32 | Prefetch address |
| pf_depth | output | 3 | Depth tag of the request |

## Verification
The embedded assertions check, on every cycle, the properties of the request stream itself. They confirm that a held request stays unchanged, that word indices rise within a line, that no zero address or zero depth is offered, and that the handshake state is correct right after a line is taken with or without survivors. Whether the right words survive can only be shown by the bench scenarios, which compare the exact sequence of addresses and depths against expectations built from the requirements. That covers the high-bit compare, hint indexing for aligned and unaligned offsets, the zero and self-address exclusions, and the depth limit including its wrap-around edge.

// File: rtl/pf_pkg.sv
// Package: default geometry shared by the pointer-scan prefetch blocks.
// Assumes a 32-bit virtual address space and 64-byte lines.
package pf_pkg;
    localparam int PF_ADDR_W   = 32;  // width of a virtual address and of a line word
    localparam int PF_WORDS    = 16;  // words per cache line
    localparam int PF_CMP_BITS = 8;   // high address bits compared for a candidate
    localparam int PF_DEPTH_W  = 3;   // width of the depth tag
endpackage

// File: rtl/pf_cand_scan.sv
// Candidate scanner: purely combinational. For each line word it decides
// whether a prefetch should be issued. A word survives when its high bits
// equal the line's, it is not zero or the line base, the load's hint vector
// selects its distance from the touched byte, and the child depth fits the
// limit. Assumes ADDR_W is a multiple of 8 and WORDS is a power of two.
module pf_cand_scan #(
    parameter int ADDR_W   = pf_pkg::PF_ADDR_W,
    parameter int WORDS    = pf_pkg::PF_WORDS,
    parameter int CMP_BITS = pf_pkg::PF_CMP_BITS,
    parameter int DEPTH_W  = pf_pkg::PF_DEPTH_W,
    localparam int WB      = ADDR_W / 8,
    localparam int LINE_B  = WORDS * WB,
    localparam int OFF_W   = $clog2(LINE_B),
    localparam int WSH     = $clog2(WB),
    localparam int HIDX_W  = OFF_W - WSH
) (
    input  logic [ADDR_W-1:0]       line_addr,
    input  logic [WORDS*ADDR_W-1:0] line_data,
    input  logic [OFF_W-1:0]        load_off,
    input  logic [WORDS-1:0]        hint,
    input  logic [DEPTH_W-1:0]      src_depth,
    input  logic [DEPTH_W-1:0]      max_depth,
    output logic [WORDS-1:0]        cand_mask,
    output logic [DEPTH_W-1:0]      child_depth
);
    logic [ADDR_W-1:0]  line_base;
    logic [DEPTH_W:0]   next_depth;
    logic               depth_ok;

    // Base address of the line, used to exclude self-pointers.
    assign line_base = line_addr & ~ADDR_W'(LINE_B - 1);

    // Child depth computed one bit wider so a saturated parent cannot wrap.
    assign next_depth  = {1'b0, src_depth} + (DEPTH_W+1)'(1);
    assign depth_ok    = next_depth <= {1'b0, max_depth};
    assign child_depth = next_depth[DEPTH_W-1:0];

    // One qualifying slice per word of the line.
    for (genvar i = 0; i < WORDS; i++) begin : g_word
        localparam logic [OFF_W-1:0] BPOS = OFF_W'(i * WB);
        logic [ADDR_W-1:0] word;
        logic [HIDX_W-1:0] hidx;
        logic hi_eq, not_zero, not_self, reach, hinted;

        assign word     = line_data[i*ADDR_W +: ADDR_W];
        assign hi_eq    = word[ADDR_W-1 -: CMP_BITS] == line_addr[ADDR_W-1 -: CMP_BITS];
        assign not_zero = |word;
        assign not_self = word != line_base;
        assign reach    = load_off <= BPOS;
        assign hidx     = HIDX_W'((BPOS - load_off) >> WSH);
        assign hinted   = hint[hidx];
        assign cand_mask[i] = hi_eq & not_zero & not_self & reach & hinted & depth_ok;
    end
endmodule

// File: rtl/pf_issue_queue.sv
// Issue queue: captures one line's surviving words and its depth tag, then
// offers them one per cycle, lowest word index first, on a valid/ready port.
// Assumes load is raised only while busy is low.
module pf_issue_queue #(
    parameter int ADDR_W  = pf_pkg::PF_ADDR_W,
    parameter int WORDS   = pf_pkg::PF_WORDS,
    parameter int DEPTH_W = pf_pkg::PF_DEPTH_W,
    localparam int IDX_W  = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [WORDS-1:0]        cand_mask,
    input  logic [WORDS*ADDR_W-1:0] line_data,
    input  logic [DEPTH_W-1:0]      new_depth,
    input  logic                    pf_ready,
    output logic                    pf_valid,
    output logic [ADDR_W-1:0]       pf_addr,
    output logic [DEPTH_W-1:0]      pf_depth,
    output logic                    busy
);
    logic [WORDS-1:0]        pend_q;
    logic [WORDS*ADDR_W-1:0] data_q;
    logic [DEPTH_W-1:0]      depth_q;
    logic [IDX_W-1:0]        sel;

    // Priority pick: the lowest pending word index wins.
    always_comb begin
        sel = '0;
        for (int i = WORDS - 1; i >= 0; i--) begin
            if (pend_q[i]) sel = IDX_W'(i);
        end
    end

    assign pf_valid = |pend_q;
    assign busy     = pf_valid;
    assign pf_addr  = data_q[sel*ADDR_W +: ADDR_W];
    assign pf_depth = depth_q;

    // Capture a new line or retire the word just taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            data_q  <= '0;
            depth_q <= '0;
        end else if (load) begin
            pend_q  <= cand_mask;
            data_q  <= line_data;
            depth_q <= new_depth;
        end else if (pf_valid && pf_ready) begin
            pend_q  <= pend_q & ~(WORDS'(1) << sel);
        end
    end

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr) && $stable(pf_depth)));

    // R7
    ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && pf_ready) |=> (!pf_valid || sel > $past(sel)));

    // R6
    nonzero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (pf_addr != '0));
endmodule

// File: rtl/ptr_prefetch_gen.sv
// Top: hint-filtered pointer-scan prefetch generator. Accepts one filled
// line when idle, filters its words through the scanner, and serialises the
// survivors as prefetch requests. Assumes the consumer may stall pf_ready.
module ptr_prefetch_gen #(
    parameter int ADDR_W   = pf_pkg::PF_ADDR_W,
    parameter int WORDS    = pf_pkg::PF_WORDS,
    parameter int CMP_BITS = pf_pkg::PF_CMP_BITS,
    parameter int DEPTH_W  = pf_pkg::PF_DEPTH_W,
    localparam int OFF_W   = $clog2(WORDS * (ADDR_W / 8))
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fill_valid,
    output logic                    fill_ready,
    input  logic [ADDR_W-1:0]       fill_addr,
    input  logic [WORDS*ADDR_W-1:0] fill_data,
    input  logic [DEPTH_W-1:0]      fill_depth,
    input  logic [OFF_W-1:0]        fill_off,
    input  logic [WORDS-1:0]        fill_hint,
    input  logic [DEPTH_W-1:0]      max_depth,
    output logic                    pf_valid,
    input  logic                    pf_ready,
    output logic [ADDR_W-1:0]       pf_addr,
    output logic [DEPTH_W-1:0]      pf_depth
);
    logic [WORDS-1:0]   cand_mask;
    logic [DEPTH_W-1:0] child_depth;
    logic               busy;
    logic               accept;

    // A line is taken only when no request of the previous line is pending.
    assign fill_ready = !busy;
    assign accept     = fill_valid && fill_ready;

    pf_cand_scan #(
        .ADDR_W(ADDR_W), .WORDS(WORDS), .CMP_BITS(CMP_BITS), .DEPTH_W(DEPTH_W)
    ) u_scan (
        .line_addr  (fill_addr),
        .line_data  (fill_data),
        .load_off   (fill_off),
        .hint       (fill_hint),
        .src_depth  (fill_depth),
        .max_depth  (max_depth),
        .cand_mask  (cand_mask),
        .child_depth(child_depth)
    );

    pf_issue_queue #(
        .ADDR_W(ADDR_W), .WORDS(WORDS), .DEPTH_W(DEPTH_W)
    ) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .cand_mask(cand_mask),
        .line_data(fill_data),
        .new_depth(child_depth),
        .pf_ready (pf_ready),
        .pf_valid (pf_valid),
        .pf_addr  (pf_addr),
        .pf_depth (pf_depth),
        .busy     (busy)
    );

    // R8
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && |cand_mask) |=> (pf_valid && !fill_ready));

    // R8
    empty_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !(|cand_mask)) |=> (fill_ready && !pf_valid));

    // R4
    depth_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (pf_depth != '0));
endmodule

// File: tb/tb_ptr_prefetch_gen.sv
// Scoreboard bench: the driver task computes the expected requests of each
// line from the requirements and queues them; a monitor compares the design's
// requests against the queue as they are handed over.
module tb_ptr_prefetch_gen;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fill_valid = 1'b0;
    logic         fill_ready;
    logic [31:0]  fill_addr = '0;
    logic [511:0] fill_data = '0;
    logic [2:0]   fill_depth = '0;
    logic [5:0]   fill_off = '0;
    logic [15:0]  fill_hint = '0;
    logic [2:0]   max_depth = 3'd4;
    logic         pf_valid;
    logic         pf_ready = 1'b1;
    logic [31:0]  pf_addr;
    logic [2:0]   pf_depth;

    int errors = 0;
    int checks = 0;
    int rdy_mode = 0;
    int cyc = 0;
    string cur_req = "R2";
    logic [31:0] line_w [16];
    logic [34:0] sb_q [$];

    always #2 clk = ~clk;   // 250 MHz

    ptr_prefetch_gen dut (
        .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_ready(fill_ready),
        .fill_addr(fill_addr), .fill_data(fill_data), .fill_depth(fill_depth),
        .fill_off(fill_off), .fill_hint(fill_hint), .max_depth(max_depth),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr), .pf_depth(pf_depth)
    );

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
        finish_run();
    end

    // Consumer back-pressure pattern, changed away from the active edge.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 pf_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
    end

    // Monitor: compare each handed-over request with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && pf_valid) begin
            checks++;
            if (fill_ready) begin
                errors++;
                $display("FAIL R8: fill_ready=%0b while request pending (expected 0)", fill_ready);
            end
            if (pf_ready) begin
                checks++;
                if (sb_q.size() == 0) begin
                    errors++;
                    $display("FAIL %s: unexpected request addr=%h depth=%0d (expected none)",
                             cur_req, pf_addr, pf_depth);
                end else begin
                    logic [34:0] e;
                    e = sb_q.pop_front();
                    if ({pf_addr, pf_depth} != e) begin
                        errors++;
                        $display("FAIL %s: got addr=%h depth=%0d expected addr=%h depth=%0d",
                                 cur_req, pf_addr, pf_depth, e[34:3], e[2:0]);
                    end
                end
            end
        end
    end

    // Driver: work out the expected survivors, queue them, present the line.
    task automatic send_line(input logic [31:0] addr, input logic [2:0] dep,
                             input logic [5:0] off, input logic [15:0] hint,
                             input logic [2:0] maxd);
        logic [31:0] base;
        base = {addr[31:6], 6'b0};
        for (int i = 0; i < 16; i++) begin
            int rel;
            logic keep;
            rel  = 4 * i - int'(off);
            keep = (line_w[i][31:24] == addr[31:24])        // R1
                && (line_w[i] != 32'h0) && (line_w[i] != base) // R6
                && (rel >= 0) && hint[rel >> 2]              // R3
                && ((int'(dep) + 1) <= int'(maxd));          // R5
            if (keep) sb_q.push_back({line_w[i], dep + 3'd1}); // R2, R4
        end
        @(posedge clk); #1;
        while (!fill_ready) begin @(posedge clk); #1; end
        for (int i = 0; i < 16; i++) fill_data[32*i +: 32] = line_w[i];
        fill_addr = addr; fill_depth = dep; fill_off = off;
        fill_hint = hint; max_depth = maxd; fill_valid = 1'b1;
        @(posedge clk); #1;
        fill_valid = 1'b0;
    endtask

    // Wait until the line drains, then check nothing expected is missing.
    task automatic drain(input string req);
        int n = 0;
        while ((sb_q.size() != 0 || pf_valid || !fill_ready) && n < 200) begin
            @(negedge clk); n++;
        end
        repeat (3) @(negedge clk);
        checks++;
        if (sb_q.size() != 0 || !fill_ready) begin
            errors++;
            $display("FAIL %s: %0d requests missing, fill_ready=%0b (expected 0 missing, ready 1)",
                     req, sb_q.size(), fill_ready);
            sb_q.delete();
        end
    endtask

    task automatic fill_pointers(input logic [31:0] seed);
        for (int i = 0; i < 16; i++) line_w[i] = seed + 32'(i * 68 + 4);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        checks++;
        if (fill_ready !== 1'b1 || pf_valid !== 1'b0) begin
            errors++;
            $display("FAIL R8: reset fill_ready=%0b pf_valid=%0b (expected 1 0)", fill_ready, pf_valid);
        end

        // R1 R6: mixed words, all hints set
        cur_req = "R1";
        for (int i = 0; i < 16; i++) line_w[i] = 32'h4000_0000 + 32'(i * 256);
        line_w[0] = 32'h4000_2000;
        line_w[1] = 32'h0000_0000;
        line_w[2] = 32'h4000_1240;
        line_w[3] = 32'h7000_0000;
        line_w[4] = 32'h40FF_FFFC;
        line_w[5] = 32'h3FFF_FFFC;
        send_line(32'h4000_1240, 3'd0, 6'd0, 16'hFFFF, 3'd4);
        drain("R1");

        // R3: offset 8, hints at bits 2, 6, 11 (offsets 8, 24, 44)
        cur_req = "R3";
        fill_pointers(32'h4020_0000);
        send_line(32'h4000_0080, 3'd0, 6'd8, 16'h0844, 3'd4);
        drain("R3");

        // R3: words before the touched byte dropped even with all hints
        fill_pointers(32'h4030_0000);
        send_line(32'h4000_00C0, 3'd1, 6'd12, 16'hFFFF, 3'd4);
        drain("R3");

        // R3: unaligned offset 6, only bit 1 set (word 3)
        fill_pointers(32'h4040_0000);
        send_line(32'h4000_0100, 3'd0, 6'd6, 16'h0002, 3'd4);
        drain("R3");

        // R4 R5: depth at the limit and just beyond
        cur_req = "R4";
        fill_pointers(32'h4050_0000);
        send_line(32'h4000_0140, 3'd3, 6'd0, 16'h00F0, 3'd4);
        drain("R4");
        cur_req = "R5";
        send_line(32'h4000_0140, 3'd4, 6'd0, 16'hFFFF, 3'd4);
        drain("R5");
        send_line(32'h4000_0140, 3'd7, 6'd0, 16'hFFFF, 3'd7);
        drain("R5");

        // R5 R8: empty line leaves ready high
        cur_req = "R8";
        send_line(32'h4000_0180, 3'd0, 6'd0, 16'h0000, 3'd4);
        @(negedge clk);
        checks++;
        if (fill_ready !== 1'b1 || pf_valid !== 1'b0) begin
            errors++;
            $display("FAIL R8: after empty line fill_ready=%0b pf_valid=%0b (expected 1 0)",
                     fill_ready, pf_valid);
        end

        // R7 R8: back-to-back lines under consumer stalls
        cur_req = "R7";
        rdy_mode = 1;
        fill_pointers(32'h4060_0000);
        send_line(32'h4000_01C0, 3'd2, 6'd0, 16'hA5A5, 3'd6);
        fill_pointers(32'h4070_0000);
        send_line(32'h4000_0200, 3'd0, 6'd4, 16'h7FFF, 3'd1);
        drain("R7");
        rdy_mode = 0;

        finish_run();
    end
endmodule